// File: doc/BRIEF.md
# Packet Number Pool Manager

This block hands out and takes back packet numbers for a network controller's buffer memory, which is split into a fixed number of equal packet pages. A host drives it with 3-bit commands. It can request a free number, free a number again, drop or free the oldest received packet, queue a number for transmission, and clear the transmit queues. The packet storage itself sits elsewhere. This block only tracks which numbers are in use and where each number is queued.

An allocation that finds no free number does not fail for good. The request stays open with the `failed` flag set, and it is granted on the first cycle after some release frees a number. Releases are deliberately slow. `busy` stays high for `REL_LAT` cycles, and the number goes back to the pool only when `busy` drops. Three packet-number queues run alongside the pool: received, transmit-pending and transmit-complete. The MAC side fills the received and completion queues over valid/ready. A transmitter drains the pending queue over valid/ready. When the receive or completion queue is full, `ready` goes low and the producer must hold its number and keep `valid` asserted until `ready` returns. The host watches the queue heads directly and pops the completion queue with a strobe.

Top module: `pkt_mmu_top`

## Requirements

**Command codes on `cmd_code`, taking effect on the clock edge where `cmd_wr` is high:**

| Code | Meaning |
|------|---------|
| 0 | no operation |
| 1 | allocate |
| 2 | reset the manager |
| 3 | drop the receive head |
| 4 | free the receive head |
| 5 | free the number in `pnr_q` |
| 6 | queue `pnr_q` for transmit |
| 7 | clear both transmit queues |

**Requirements:**

- R1: Allocate (code 1) with a free number available: `failed` reads 1 in the cycle after the command. One cycle later `failed` reads 0, `alloc_int` reads 1, and `alloc_pn` holds the lowest-numbered free packet.
- R2: Allocate with every number in use: `failed` stays 1 and the request stays pending. It is granted one cycle after a release returns a number, and that number appears on `alloc_pn`.
- R3: After hardware reset, or one cycle after code 2, the block is in its starting state:
  - `failed` = 1, `pnr_q` = 0, `busy` = 0, `alloc_int` = 0, `rel_err` = 0;
  - all three queues are empty;
  - every number is free;
  - any pending allocation is dropped.
- R4: Code 5 frees the number in `pnr_q`. `busy` reads 1 for exactly `REL_LAT` cycles, starting the cycle after the command, and the number returns to the pool when `busy` falls.
- R5: Code 4 pops the receive queue head and frees that number with the same `busy` timing as R4. Code 4 on an empty receive queue does nothing: `busy` stays 0.
- R6: Code 3 pops the receive queue head without freeing the number.
- R7: Code 6 appends `pnr_q` to the transmit-pending queue. That queue is presented on `txq_valid`/`txq_pn` and advances only on a cycle with `txq_valid` and `txq_ready` both high.
- R8: Code 7 empties the transmit-pending and completion queues without freeing any number, so an allocation with the pool full still fails afterwards.
- R9: Freeing a number that is not in use changes nothing in the pool. When that release ends, `rel_err` is set, and it stays set until reset or code 2.
- R10: The FIFO port shows the receive head (`rx_head`, valid only when `rx_empty` = 0) and the completion head (`cmp_head`, valid only when `cmp_empty` = 0). `cmp_pop` removes the completion head.
- R11: `rx_in_ready` and `cmp_in_ready` are low while their queue holds `NUM_PKTS` entries. A code 4 or 5 issued while `busy` is 1 is ignored.
- R12: `alloc_int` is cleared by the next allocate command and by code 2.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_wr | input | 1 | command strobe |
| cmd_code | input | 3 | command code |
| pnr_wr | input | 1 | packet number register write |
| pnr_wdata | input | PN_W | packet number register write data |
| pnr_q | output | PN_W | packet number register |
| busy | output | 1 | release in progress |
| failed | output | 1 | allocation not (yet) satisfied |
| alloc_int | output | 1 | allocation complete flag |
| alloc_pn | output | PN_W | last allocated number |
| rel_err | output | 1 | sticky: release of a free number |
| rx_in_valid | input | 1 | received packet number valid |
| rx_in_pn | input | PN_W | received packet number |
| rx_in_ready | output | 1 | receive queue accepts |
| rx_head | output | PN_W | receive queue head |
| rx_empty | output | 1 | receive queue empty |
| txq_valid | output | 1 | transmit-pending head valid |
| txq_pn | output | PN_W | transmit-pending head |
| txq_ready | input | 1 | transmitter takes head |
| cmp_in_valid | input | 1 | completed packet number valid |
| cmp_in_pn | input | PN_W | completed packet number |
| cmp_in_ready | output | 1 | completion queue accepts |
| cmp_head | output | PN_W | completion queue head |
| cmp_empty | output | 1 | completion queue empty |
| cmp_pop | input | 1 | remove completion head |

## Verification

The assertions take for granted that the host keeps to the command discipline:

- no second allocate while one is pending;
- no change to `pnr_q` while a release is busy;
- only numbers the host currently owns are pushed into the receive or completion queues;
- `NUM_PKTS` is a power of two.

The random stimulus follows these rules. It allocates only when the model pool has a free number. It waits out every release before the next command, except in one directed case that deliberately issues a release while `busy` is high. It pushes only model-owned numbers into the receive queue, and keeps at most eight of them queued.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_RESET   = 3'd2,
    CMD_RX_DROP = 3'd3,
    CMD_RX_FREE = 3'd4,
    CMD_FREE_PN = 3'd5,
    CMD_TX_ENQ  = 3'd6,
    CMD_TX_CLR  = 3'd7
  } mmu_cmd_e;
endpackage

// File: rtl/pn_fifo.sv
module pn_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         do_push, do_pop;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= din;
  end

  AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R8
  AST_FIFO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop && !flush) |=> !empty); // R10
endmodule

// File: rtl/pn_alloc.sv
module pn_alloc #(
  parameter int NUM_PKTS = 16,
  parameter int PN_W     = 4,
  parameter int REL_LAT  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            alloc_req,
  input  logic            rel_req,
  input  logic [PN_W-1:0] rel_pn,
  output logic            failed,
  output logic            busy,
  output logic            alloc_int,
  output logic [PN_W-1:0] alloc_pn,
  output logic            rel_err
);
  localparam int CW = $clog2(REL_LAT) + 1;

  logic [NUM_PKTS-1:0] used_q, used_d, set_mask, clr_mask;
  logic                pend_q;
  logic [CW-1:0]       cnt_q;
  logic [PN_W-1:0]     rel_pn_q;
  logic                gnt_found, grant, rel_done, rel_hit;
  logic [PN_W-1:0]     gnt_idx;

  // lowest free number
  always_comb begin
    gnt_found = 1'b0;
    gnt_idx   = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        gnt_found = 1'b1;
        gnt_idx   = PN_W'(i);
      end
    end
  end

  assign grant    = pend_q && gnt_found;
  assign rel_done = busy && (cnt_q == '0);
  assign rel_hit  = used_q[rel_pn_q];

  for (genvar g = 0; g < NUM_PKTS; g++) begin : g_mask
    assign set_mask[g] = grant && (gnt_idx == PN_W'(g));
    assign clr_mask[g] = rel_done && rel_hit && (rel_pn_q == PN_W'(g));
  end

  assign used_d = (used_q | set_mask) & ~clr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      used_q    <= '0;
      pend_q    <= 1'b0;
      failed    <= 1'b1;
      alloc_int <= 1'b0;
      alloc_pn  <= '0;
      busy      <= 1'b0;
      cnt_q     <= '0;
      rel_pn_q  <= '0;
      rel_err   <= 1'b0;
    end else begin
      used_q <= used_d;
      if (grant) begin
        pend_q    <= 1'b0;
        failed    <= 1'b0;
        alloc_pn  <= gnt_idx;
        alloc_int <= 1'b1;
      end else if (alloc_req && !pend_q) begin
        pend_q    <= 1'b1;
        failed    <= 1'b1;
        alloc_int <= 1'b0;
      end
      if (rel_req && !busy) begin
        busy     <= 1'b1;
        cnt_q    <= CW'(REL_LAT - 1);
        rel_pn_q <= rel_pn;
      end else if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          if (!rel_hit) rel_err <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_FAILED_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !pend_q && !clr) |=> failed); // R1
  AST_GRANT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(failed) && !$past(clr)) |-> (used_q[alloc_pn] && alloc_int)); // R1
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !gnt_found && !clr) |=> failed); // R2
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !busy && !clr) |=> busy); // R4
  AST_REL_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_err && !clr) |=> rel_err); // R9
endmodule

// File: rtl/pkt_mmu_top.sv
module pkt_mmu_top
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PKTS = 16,
  parameter int REL_LAT  = 4,
  localparam int PN_W    = $clog2(NUM_PKTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [2:0]      cmd_code,
  input  logic            pnr_wr,
  input  logic [PN_W-1:0] pnr_wdata,
  output logic [PN_W-1:0] pnr_q,
  output logic            busy,
  output logic            failed,
  output logic            alloc_int,
  output logic [PN_W-1:0] alloc_pn,
  output logic            rel_err,
  input  logic            rx_in_valid,
  input  logic [PN_W-1:0] rx_in_pn,
  output logic            rx_in_ready,
  output logic [PN_W-1:0] rx_head,
  output logic            rx_empty,
  output logic            txq_valid,
  output logic [PN_W-1:0] txq_pn,
  input  logic            txq_ready,
  input  logic            cmp_in_valid,
  input  logic [PN_W-1:0] cmp_in_pn,
  output logic            cmp_in_ready,
  output logic [PN_W-1:0] cmp_head,
  output logic            cmp_empty,
  input  logic            cmp_pop
);
  mmu_cmd_e        cmd;
  logic            mmu_clr, tx_clr, rel_rx, rel_pnr, rx_pop;
  logic            rx_full, txq_empty, txq_full, cmp_full;
  logic [PN_W-1:0] rel_pn;

  assign cmd     = mmu_cmd_e'(cmd_code);
  assign mmu_clr = cmd_wr && (cmd == CMD_RESET);
  assign tx_clr  = mmu_clr || (cmd_wr && (cmd == CMD_TX_CLR));
  assign rel_rx  = cmd_wr && (cmd == CMD_RX_FREE) && !rx_empty && !busy;
  assign rel_pnr = cmd_wr && (cmd == CMD_FREE_PN) && !busy;
  assign rx_pop  = rel_rx || (cmd_wr && (cmd == CMD_RX_DROP));
  assign rel_pn  = rel_rx ? rx_head : pnr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || mmu_clr) pnr_q <= '0;
    else if (pnr_wr)       pnr_q <= pnr_wdata;
  end

  pn_alloc #(.NUM_PKTS(NUM_PKTS), .PN_W(PN_W), .REL_LAT(REL_LAT)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mmu_clr),
    .alloc_req (cmd_wr && (cmd == CMD_ALLOC)),
    .rel_req   (rel_rx || rel_pnr),
    .rel_pn    (rel_pn),
    .failed    (failed),
    .busy      (busy),
    .alloc_int (alloc_int),
    .alloc_pn  (alloc_pn),
    .rel_err   (rel_err)
  );

  assign rx_in_ready = !rx_full;
  pn_fifo #(.DEPTH(NUM_PKTS), .W(PN_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (mmu_clr),
    .push  (rx_in_valid && rx_in_ready),
    .din   (rx_in_pn),
    .pop   (rx_pop),
    .head  (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign txq_valid = !txq_empty;
  pn_fifo #(.DEPTH(NUM_PKTS), .W(PN_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_clr),
    .push  (cmd_wr && (cmd == CMD_TX_ENQ)),
    .din   (pnr_q),
    .pop   (txq_valid && txq_ready),
    .head  (txq_pn),
    .empty (txq_empty),
    .full  (txq_full)
  );

  assign cmp_in_ready = !cmp_full;
  pn_fifo #(.DEPTH(NUM_PKTS), .W(PN_W)) u_cmpq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_clr),
    .push  (cmp_in_valid && cmp_in_ready),
    .din   (cmp_in_pn),
    .pop   (cmp_pop),
    .head  (cmp_head),
    .empty (cmp_empty),
    .full  (cmp_full)
  );

  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == CMD_TX_CLR) |=> (!txq_valid && cmp_empty)); // R8
  AST_MMU_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_clr |=> (failed && pnr_q == '0 && !busy && rx_empty && !alloc_int)); // R3
  AST_RX_FREE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_rx && !mmu_clr) |=> busy); // R5
  AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_in_ready |-> !rx_empty); // R11
  AST_TXQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_valid && !txq_ready && !tx_clr) |=> txq_valid); // R7
  AST_TXQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    txq_full |-> txq_valid); // R7
endmodule

// File: tb/tb_pkt_mmu_top.sv
module tb_pkt_mmu_top;
  localparam int NUM = 16;
  localparam int LAT = 4;
  localparam int PW  = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, pnr_wr = 0, rx_in_valid = 0, txq_ready = 0, cmp_in_valid = 0, cmp_pop = 0;
  logic [2:0] cmd_code = 0;
  logic [PW-1:0] pnr_wdata = 0, rx_in_pn = 0, cmp_in_pn = 0;
  logic [PW-1:0] pnr_q, alloc_pn, rx_head, txq_pn, cmp_head;
  logic busy, failed, alloc_int, rel_err, rx_in_ready, rx_empty, txq_valid, cmp_in_ready, cmp_empty;

  int total = 0, bad = 0;
  bit own [NUM];
  int rxm [$];
  bit errm;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_mmu_top #(.NUM_PKTS(NUM), .REL_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata), .pnr_q(pnr_q), .busy(busy),
    .failed(failed), .alloc_int(alloc_int), .alloc_pn(alloc_pn), .rel_err(rel_err),
    .rx_in_valid(rx_in_valid), .rx_in_pn(rx_in_pn), .rx_in_ready(rx_in_ready),
    .rx_head(rx_head), .rx_empty(rx_empty), .txq_valid(txq_valid), .txq_pn(txq_pn),
    .txq_ready(txq_ready), .cmp_in_valid(cmp_in_valid), .cmp_in_pn(cmp_in_pn),
    .cmp_in_ready(cmp_in_ready), .cmp_head(cmp_head), .cmp_empty(cmp_empty),
    .cmp_pop(cmp_pop)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NUM; i++) if (!own[i]) return i;
    return -1;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NUM; i++) own[i] = 0;
    rxm.delete();
    errm = 0;
  endfunction

  task automatic do_cmd(int c);
    cmd_code = 3'(c); cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic set_pnr(int v);
    pnr_wdata = PW'(v); pnr_wr = 1;
    @(negedge clk); pnr_wr = 0;
  endtask

  task automatic rx_push(int v);
    rx_in_pn = PW'(v); rx_in_valid = 1;
    @(negedge clk); rx_in_valid = 0;
  endtask

  task automatic alloc_ok();
    int e;
    e = lowest_free();
    do_cmd(1);
    chk("R1 failed after cmd", failed, 1);
    chk("R12 int cleared by cmd", alloc_int, 0);
    @(negedge clk);
    chk("R1 failed cleared", failed, 0);
    chk("R1 alloc_pn lowest", alloc_pn, e);
    chk("R1 alloc_int", alloc_int, 1);
    own[e] = 1;
  endtask

  // called right after a release command; checks busy window and applies model
  task automatic rel_wait(string tag, int v);
    chk({tag, " busy rises"}, busy, 1);
    repeat (LAT - 1) @(negedge clk);
    chk({tag, " busy held"}, busy, 1);
    @(negedge clk);
    chk({tag, " busy falls"}, busy, 0);
    if (!own[v]) errm = 1; else own[v] = 0;
    chk("R9 rel_err", rel_err, errm);
  endtask

  task automatic rel_pnr(int v);
    set_pnr(v);
    do_cmd(5);
    rel_wait("R4", v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5eed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk("R3 failed", failed, 1);
    chk("R3 pnr", pnr_q, 0);
    chk("R3 busy", busy, 0);
    chk("R3 alloc_int", alloc_int, 0);
    chk("R3 rx_empty", rx_empty, 1);
    chk("R3 txq_valid", txq_valid, 0);
    chk("R3 cmp_empty", cmp_empty, 1);

    // R1 fill the pool
    for (int i = 0; i < NUM; i++) alloc_ok();

    // R2 pool exhausted, pending
    do_cmd(1);
    repeat (3) begin
      chk("R2 failed pending", failed, 1);
      @(negedge clk);
    end
    chk("R12 alloc_int cleared", alloc_int, 0);
    rel_pnr(5);
    chk("R2 still pending at busy fall", failed, 1);
    @(negedge clk);
    chk("R2 granted", failed, 0);
    chk("R2 granted number", alloc_pn, 5);
    own[5] = 1;

    // R10 R6 R5 receive queue
    rx_push(3); rx_push(9);
    chk("R10 rx_empty", rx_empty, 0);
    chk("R10 rx_head", rx_head, 3);
    do_cmd(3);
    chk("R6 drop advances head", rx_head, 9);
    chk("R6 no busy", busy, 0);
    do_cmd(4);
    rel_wait("R5", 9);
    chk("R5 rx empty after free", rx_empty, 1);
    do_cmd(4);
    chk("R5 empty free ignored", busy, 0);
    alloc_ok();
    chk("R5 freed number reused", alloc_pn, 9);
    rel_pnr(3);   // still owned after R6 drop: no error
    alloc_ok();
    chk("R6 drop kept number", alloc_pn, 3);

    // R9 double release
    rel_pnr(9);
    rel_pnr(9);
    chk("R9 flagged", rel_err, 1);
    alloc_ok();

    // R7 transmit queue
    set_pnr(2); do_cmd(6);
    set_pnr(7); do_cmd(6);
    chk("R7 txq valid", txq_valid, 1);
    chk("R7 txq head", txq_pn, 2);
    @(negedge clk);
    chk("R7 held without ready", txq_pn, 2);
    txq_ready = 1; @(negedge clk); txq_ready = 0;
    chk("R7 advanced", txq_pn, 7);

    // R10 completion queue
    cmp_in_pn = 4; cmp_in_valid = 1; @(negedge clk);
    cmp_in_pn = 6; @(negedge clk); cmp_in_valid = 0;
    chk("R10 cmp head", cmp_head, 4);
    cmp_pop = 1; @(negedge clk); cmp_pop = 0;
    chk("R10 cmp pop", cmp_head, 6);

    // R8 clear tx queues, no memory freed
    do_cmd(7);
    chk("R8 txq empty", txq_valid, 0);
    chk("R8 cmp empty", cmp_empty, 1);
    do_cmd(1);
    @(negedge clk); @(negedge clk);
    chk("R8 pool still full", failed, 1);

    // R3 reset command
    set_pnr(11);
    rx_push(1);
    do_cmd(2);
    model_reset();
    chk("R3 cmd failed", failed, 1);
    chk("R3 cmd pnr", pnr_q, 0);
    chk("R3 cmd rel_err", rel_err, 0);
    chk("R3 cmd rx_empty", rx_empty, 1);
    @(negedge clk);
    chk("R3 pending dropped", failed, 1);
    alloc_ok();
    chk("R3 pool freed", alloc_pn, 0);

    // R11 release while busy ignored
    set_pnr(0);
    do_cmd(5);
    do_cmd(5);
    repeat (LAT - 2) @(negedge clk);
    chk("R11 busy held", busy, 1);
    @(negedge clk);
    chk("R11 busy ends on time", busy, 0);
    own[0] = 0;
    repeat (LAT + 1) @(negedge clk);
    chk("R11 second ignored busy", busy, 0);
    chk("R11 second ignored err", rel_err, 0);

    // R11 receive back-pressure
    for (int i = 0; i < NUM; i++) rx_push(i);
    chk("R11 rx not ready when full", rx_in_ready, 0);
    do_cmd(2);
    model_reset();
    chk("R11 rx ready after flush", rx_in_ready, 1);

    // random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 2))
        0: if (lowest_free() >= 0) alloc_ok();
        1: rel_pnr(int'($urandom_range(0, NUM - 1)));
        default: begin
          v = int'($urandom_range(0, NUM - 1));
          if (own[v] && rxm.size() < 8) begin
            rx_push(v);
            rxm.push_back(v);
          end
          if (rxm.size() > 0) begin
            chk("R10 rand rx head", rx_head, rxm[0]);
            if ($urandom_range(0, 1) == 0) begin
              do_cmd(3);
              void'(rxm.pop_front());
            end else begin
              v = rxm.pop_front();
              do_cmd(4);
              rel_wait("R5 rand", v);
            end
          end
          chk("R10 rand rx empty", rx_empty, (rxm.size() == 0) ? 1 : 0);
        end
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule